// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block is the control engine that drains received frames out of a receive byte FIFO into host memory buffers. Host buffers are described by a singly linked chain of descriptors, each three 32-bit words long: a link to the next descriptor at offset 0, a command/status word at offset 4 and a buffer address at offset 8. The engine loads a descriptor, checks whether it may use it, waits for enough data in the FIFO, and copies the frame into the buffer in bursts. It then writes a status word back and follows the link.

The engine never touches data bytes itself. Every memory access goes out as one burst request that carries an address, a byte length, a direction and a descriptor/data marker. An external bus mover performs the burst. For descriptor reads it returns the three descriptor words on `rd_link`, `rd_cmdsts` and `rd_bufptr` together with the completion pulse `bus_done`. Back-pressure works as follows:
- Once `bus_req` rises, `bus_addr`, `bus_len`, `bus_we`, `bus_desc` and `bus_wdata` hold still until the cycle in which `bus_done` is sampled high. `bus_req` falls after that edge.
- A new request is raised no earlier than the following cycle, so at most one burst is outstanding.
- The bus mover may stall for any number of cycles.
- For a fragment write, the bus mover also removes `bus_len` bytes from the FIFO. The new FIFO count must be visible on `fifo_bytes` in the cycle after `bus_done`.

Software loads the first descriptor address with `ptr_wr` while the engine is idle. After that, `rx_en` lets the engine run. An internal "current descriptor done" flag records that the descriptor at `cur_ptr` has already been filled. When that flag is set and the engine is restarted, it re-reads only the link word of that descriptor instead of the whole descriptor, so a host can append descriptors to a chain that had ended.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset the engine is idle: `bus_req` and `rx_idle_irq` are 0.
- R2: In idle, with `rx_en` high and the done flag clear, the engine requests a read burst (`bus_we`=0, `bus_desc`=1) of 12 bytes at `cur_ptr`.
- R3: In idle, with `rx_en` high and the done flag set, the engine requests a 4-byte descriptor read at `cur_ptr` (link word only). It then advances using the returned link.
- R4: After a full descriptor read, if the ownership bit (bit 31 of the command word) is 1, the engine returns to idle without a data burst. If the bit is 0, it waits on the FIFO. The 12-bit size field (bits 11:0) gives the buffer size in bytes.
- R5: While waiting, no fragment burst starts until `fifo_bytes` is nonzero and at least `drain_thr`×8, or `fifo_eof` is high.
- R6: A fragment burst is a write (`bus_we`=1, `bus_desc`=0) at the buffer address plus the bytes already written into this buffer. Its length is the smallest of `fifo_bytes`, the remaining buffer space and `MAX_BURST`.
- R7: If the buffer is full while frame bytes remain, the engine writes the status word with bit 31 (owned by host) and bit 30 (more fragments) set, bit 27 (OK) clear and the byte count in bits 11:0. It then continues the same frame in the descriptor at the link.
- R8: When the frame is fully drained (`fifo_eof` high and `fifo_bytes` zero), the engine writes a 4-byte status word at `cur_ptr`+4 with bit 31 set, bit 30 clear, bit 27 = not `fifo_ovr`, bit 25 = `fifo_ovr` and bits 11:0 = bytes written into this buffer.
- R9: After a status write or a link refresh, a zero link returns the engine to idle with `cur_ptr` unchanged. A nonzero link becomes `cur_ptr` and a full read of it follows.
- R10: Each entry into idle raises `rx_idle_irq` for exactly one cycle. No request is pending during that cycle.
- R11: While `bus_req` is high and `bus_done` is low, the request fields stay unchanged and `bus_req` stays high.
- R12: `ptr_wr` in idle loads `ptr_in` into `cur_ptr` and clears the done flag, so the next start is a full read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled in idle |
| ptr_wr | input | 1 | Load descriptor pointer (idle only) |
| ptr_in | input | AW | Descriptor pointer value to load |
| drain_thr | input | THR_W | Drain threshold in 8-byte units |
| fifo_bytes | input | LW | Bytes of the current frame held in the FIFO |
| fifo_eof | input | 1 | The end of the current frame is in the FIFO |
| fifo_ovr | input | 1 | The current frame suffered an overrun |
| bus_req | output | 1 | Burst request, held until done |
| bus_we | output | 1 | 1 = write to memory, 0 = read |
| bus_desc | output | 1 | 1 = descriptor access, 0 = frame data |
| bus_addr | output | AW | Burst byte address |
| bus_len | output | LW | Burst length in bytes |
| bus_wdata | output | 32 | Status word for descriptor writes |
| bus_done | input | 1 | Burst completion pulse |
| rd_link | input | AW | Link word returned with a descriptor read |
| rd_cmdsts | input | 32 | Command word returned with a descriptor read |
| rd_bufptr | input | AW | Buffer address returned with a descriptor read |
| cur_ptr | output | AW | Current descriptor address |
| rx_idle_irq | output | 1 | One-cycle pulse on entering idle |

## Verification
The bench uses the default parameters: 32-bit addresses, 12-bit lengths, a 5-bit threshold field and a 32-byte burst cap. With a 32-byte cap and buffers of 20 to 100 bytes, each of the three length limits becomes the binding one in turn. A frame that spans two descriptors reaches the more-fragments path and the link-following path. Small thresholds, such as 16 bytes, let the bench hold the FIFO just below the threshold and then just above it.

// File: rtl/rx_desc_dma_pkg.sv
package rx_desc_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_REF,
    S_ADV,
    S_BLK,
    S_FRAG,
    S_DWR
  } rxd_state_e;

  localparam int OWN_B      = 31;
  localparam int MORE_B     = 30;
  localparam int OK_B       = 27;
  localparam int OVR_B      = 25;
  localparam int SIZE_W     = 12;
  localparam int DESC_BYTES = 12;
  localparam int LINK_BYTES = 4;
  localparam int CMD_OFS    = 4;

  function automatic logic [31:0] make_status(input logic more, input logic ok,
                                              input logic ovr,
                                              input logic [SIZE_W-1:0] size);
    logic [31:0] w;
    w = '0;
    w[OWN_B]  = 1'b1;
    w[MORE_B] = more;
    w[OK_B]   = ok;
    w[OVR_B]  = ovr;
    w[SIZE_W-1:0] = size;
    return w;
  endfunction

endpackage

// File: rtl/rxd_len_calc.sv
module rxd_len_calc #(
  parameter int LW        = 12,
  parameter int MAX_BURST = 32
) (
  input  logic [LW-1:0] avail,
  input  logic [LW-1:0] room,
  output logic [LW-1:0] len
);
  localparam logic [LW-1:0] CAP = LW'(MAX_BURST);
  logic [LW-1:0] m;

  always_comb begin
    m   = (avail < room) ? avail : room;
    len = (m < CAP) ? m : CAP;
  end
endmodule

// File: rtl/rxd_burst_port.sv
module rxd_burst_port #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] s_addr,
  input  logic [LW-1:0] s_len,
  input  logic          s_we,
  input  logic          s_desc,
  input  logic [31:0]   s_wdata,
  input  logic          done,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] len,
  output logic          we,
  output logic          desc,
  output logic [31:0]   wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      addr  <= '0;
      len   <= '0;
      we    <= 1'b0;
      desc  <= 1'b0;
      wdata <= '0;
    end else if (start && !req) begin
      req   <= 1'b1;
      addr  <= s_addr;
      len   <= s_len;
      we    <= s_we;
      desc  <= s_desc;
      wdata <= s_wdata;
    end else if (done) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rx_desc_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 12,
  parameter int THR_W     = 5,
  parameter int MAX_BURST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             ptr_wr,
  input  logic [AW-1:0]    ptr_in,
  input  logic [THR_W-1:0] drain_thr,
  input  logic [LW-1:0]    fifo_bytes,
  input  logic             fifo_eof,
  input  logic             fifo_ovr,
  output logic             bus_req,
  output logic             bus_we,
  output logic             bus_desc,
  output logic [AW-1:0]    bus_addr,
  output logic [LW-1:0]    bus_len,
  output logic [31:0]      bus_wdata,
  input  logic             bus_done,
  input  logic [AW-1:0]    rd_link,
  input  logic [31:0]      rd_cmdsts,
  input  logic [AW-1:0]    rd_bufptr,
  output logic [AW-1:0]    cur_ptr,
  output logic             rx_idle_irq
);
  localparam logic [LW-1:0] DLEN = LW'(DESC_BYTES);
  localparam logic [LW-1:0] LLEN = LW'(LINK_BYTES);
  localparam logic [AW-1:0] COFS = AW'(CMD_OFS);

  rxd_state_e    st, st_n;
  logic          done_q;
  logic [AW-1:0] link_q, buf_base;
  logic [LW-1:0] buf_left, frag_cnt, frag_len, thr_bytes;
  logic [31:0]   stat_q;
  logic          go, g_we, g_desc, end_frm, spill, fin;
  logic [AW-1:0] g_addr;
  logic [LW-1:0] g_len;
  logic          unused_cmd;

  assign unused_cmd = ^rd_cmdsts[30:SIZE_W];
  assign thr_bytes  = LW'({drain_thr, 3'b000});
  assign fin        = bus_req && bus_done;

  rxd_len_calc #(.LW(LW), .MAX_BURST(MAX_BURST)) u_len (
    .avail (fifo_bytes),
    .room  (buf_left),
    .len   (frag_len)
  );

  rxd_burst_port #(.AW(AW), .LW(LW)) u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go),
    .s_addr (g_addr),
    .s_len  (g_len),
    .s_we   (g_we),
    .s_desc (g_desc),
    .s_wdata(stat_q),
    .done   (bus_done),
    .req    (bus_req),
    .addr   (bus_addr),
    .len    (bus_len),
    .we     (bus_we),
    .desc   (bus_desc),
    .wdata  (bus_wdata)
  );

  always_comb begin
    st_n    = st;
    go      = 1'b0;
    g_addr  = cur_ptr;
    g_len   = '0;
    g_we    = 1'b0;
    g_desc  = 1'b1;
    end_frm = 1'b0;
    spill   = 1'b0;
    unique case (st)
      S_IDLE: if (rx_en && !ptr_wr) st_n = done_q ? S_REF : S_RD;
      S_RD: begin
        if (!bus_req) begin
          go = 1'b1; g_len = DLEN;
        end else if (bus_done) begin
          st_n = rd_cmdsts[OWN_B] ? S_IDLE : S_BLK;
        end
      end
      S_REF: begin
        if (!bus_req) begin
          go = 1'b1; g_len = LLEN;
        end else if (bus_done) begin
          st_n = S_ADV;
        end
      end
      S_ADV: st_n = (link_q == '0) ? S_IDLE : S_RD;
      S_BLK: begin
        if ((fifo_bytes != '0 && fifo_bytes >= thr_bytes) || fifo_eof) st_n = S_FRAG;
      end
      S_FRAG: begin
        if (!bus_req) begin
          if (fifo_eof && fifo_bytes == '0) begin
            end_frm = 1'b1; st_n = S_DWR;
          end else if (buf_left == '0) begin
            spill = 1'b1; st_n = S_DWR;
          end else if (fifo_bytes == '0) begin
            st_n = S_BLK;
          end else begin
            go = 1'b1; g_addr = buf_base + AW'(frag_cnt); g_len = frag_len;
            g_we = 1'b1; g_desc = 1'b0;
          end
        end
      end
      S_DWR: begin
        if (!bus_req) begin
          go = 1'b1; g_addr = cur_ptr + COFS; g_len = LLEN; g_we = 1'b1;
        end else if (bus_done) begin
          st_n = S_ADV;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rx_idle_irq <= 1'b0;
      cur_ptr     <= '0;
      done_q      <= 1'b0;
      link_q      <= '0;
      buf_base    <= '0;
      buf_left    <= '0;
      frag_cnt    <= '0;
      stat_q      <= '0;
    end else begin
      st          <= st_n;
      rx_idle_irq <= (st_n == S_IDLE) && (st != S_IDLE);
      if (st == S_IDLE && ptr_wr) begin
        cur_ptr <= ptr_in;
        done_q  <= 1'b0;
      end
      if (st == S_RD && fin) begin
        link_q   <= rd_link;
        buf_base <= rd_bufptr;
        buf_left <= LW'(rd_cmdsts[SIZE_W-1:0]);
        frag_cnt <= '0;
      end
      if (st == S_REF && fin) link_q <= rd_link;
      if (st == S_FRAG && fin) begin
        buf_left <= buf_left - bus_len;
        frag_cnt <= frag_cnt + bus_len;
      end
      if (end_frm || spill)
        stat_q <= make_status(spill, end_frm && !fifo_ovr, end_frm && fifo_ovr,
                              frag_cnt[SIZE_W-1:0]);
      if (st == S_DWR && fin) done_q <= 1'b1;
      if (st == S_ADV && link_q != '0) begin
        cur_ptr <= link_q;
        done_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk #(
  parameter int AW        = 32,
  parameter int LW        = 12,
  parameter int MAX_BURST = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_desc,
  input logic [AW-1:0] bus_addr,
  input logic [LW-1:0] bus_len,
  input logic [31:0]   bus_wdata,
  input logic          bus_done,
  input logic          rx_idle_irq
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !bus_req && !rx_idle_irq);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_len)
                             && $stable(bus_we) && $stable(bus_desc) && $stable(bus_wdata));

  a_r11_done_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> bus_req);

  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle_irq |=> !rx_idle_irq);

  a_r10_irq_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle_irq |-> !bus_req);

  a_r8_status_owned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_desc |-> bus_wdata[31] && bus_len == LW'(4));

  a_r6_frag_len: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_desc |-> bus_we && bus_len != '0 && bus_len <= LW'(MAX_BURST));

  a_r2_read_len: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_desc && (bus_len == LW'(12) || bus_len == LW'(4)));
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.AW(AW), .LW(LW), .MAX_BURST(MAX_BURST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_desc   (bus_desc),
  .bus_addr   (bus_addr),
  .bus_len    (bus_len),
  .bus_wdata  (bus_wdata),
  .bus_done   (bus_done),
  .rx_idle_irq(rx_idle_irq)
);

// File: tb/test_rx_desc_dma.sv
module test_rx_desc_dma;
  localparam int AW = 32, LW = 12, THR_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_en = 1'b0;
  logic             ptr_wr = 1'b0;
  logic [AW-1:0]    ptr_in = '0;
  logic [THR_W-1:0] drain_thr = '0;
  logic [LW-1:0]    fifo_bytes = '0;
  logic             fifo_eof = 1'b0;
  logic             fifo_ovr = 1'b0;
  logic             bus_req, bus_we, bus_desc;
  logic [AW-1:0]    bus_addr;
  logic [LW-1:0]    bus_len;
  logic [31:0]      bus_wdata;
  logic             bus_done = 1'b0;
  logic [AW-1:0]    rd_link = '0;
  logic [31:0]      rd_cmdsts = '0;
  logic [AW-1:0]    rd_bufptr = '0;
  logic [AW-1:0]    cur_ptr;
  logic             rx_idle_irq;

  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  rx_desc_dma i_rx_desc_dma (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ptr_wr(ptr_wr), .ptr_in(ptr_in),
    .drain_thr(drain_thr), .fifo_bytes(fifo_bytes), .fifo_eof(fifo_eof),
    .fifo_ovr(fifo_ovr), .bus_req(bus_req), .bus_we(bus_we), .bus_desc(bus_desc),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .rd_link(rd_link), .rd_cmdsts(rd_cmdsts),
    .rd_bufptr(rd_bufptr), .cur_ptr(cur_ptr), .rx_idle_irq(rx_idle_irq)
  );

  task automatic chk(input logic ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected < 50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Wait for a request, check it, hold it, then complete it.
  task automatic serve(input string rq, input logic [31:0] ea, input int el,
                       input logic ewe, input logic edesc, input logic chkw,
                       input logic [31:0] ew, input logic [31:0] lnk,
                       input logic [31:0] cs, input logic [31:0] bp,
                       input int fsub, input logic en_after);
    int n = 0;
    logic [31:0] a0;
    while (!bus_req && n < 200) begin @(negedge clk); n++; end
    chk(bus_req, rq, "request raised", bus_req, 1);
    chk(bus_addr == ea, rq, "address", bus_addr, ea);
    chk(bus_len == LW'(el), rq, "length", bus_len, el);
    chk(bus_we == ewe && bus_desc == edesc, rq, "we/desc", {bus_we, bus_desc}, {ewe, edesc});
    if (chkw) chk(bus_wdata == ew, rq, "status word", bus_wdata, ew);
    a0 = bus_addr;
    @(negedge clk); @(negedge clk);
    chk(bus_req && bus_addr == a0, "R11", "request held", bus_addr, a0);
    bus_done = 1'b1; rd_link = lnk; rd_cmdsts = cs; rd_bufptr = bp;
    fifo_bytes = fifo_bytes - LW'(fsub); rx_en = en_after;
    @(negedge clk);
    bus_done = 1'b0;
  endtask

  task automatic wait_irq(input string rq);
    int n = 0;
    while (!rx_idle_irq && n < 10) begin @(negedge clk); n++; end
    chk(rx_idle_irq, rq, "idle pulse", rx_idle_irq, 1);
    @(negedge clk);
    chk(!rx_idle_irq, "R10", "pulse one cycle", rx_idle_irq, 0);
  endtask

  task automatic quiet(input string rq, input int ncy);
    logic seen = 1'b0;
    for (int i = 0; i < ncy; i++) begin @(negedge clk); seen |= bus_req; end
    chk(!seen, rq, "no request", seen, 0);
  endtask

  task automatic t_reset;
    chk(!bus_req && !rx_idle_irq, "R1", "reset outputs", {bus_req, rx_idle_irq}, 0);
  endtask

  task automatic t_owned;
    ptr_in = 32'h100; ptr_wr = 1'b1; @(negedge clk); ptr_wr = 1'b0;
    rx_en = 1'b1;
    serve("R2", 32'h100, 12, 0, 1, 0, 0, 32'h0, 32'h8000_0040, 32'h900, 0, 0);
    wait_irq("R4");
    quiet("R4", 6);
  endtask

  task automatic t_frame;
    ptr_in = 32'h200; ptr_wr = 1'b1; @(negedge clk); ptr_wr = 1'b0;
    drain_thr = 5'd2; fifo_bytes = 12'd8; rx_en = 1'b1;
    serve("R2", 32'h200, 12, 0, 1, 0, 0, 32'h0, 32'd100, 32'h1000, 0, 0);
    quiet("R5", 6);
    fifo_bytes = 12'd40;
    serve("R6", 32'h1000, 32, 1, 0, 0, 0, 0, 0, 0, 32, 0);
    serve("R6", 32'h1020, 8, 1, 0, 0, 0, 0, 0, 0, 8, 0);
    quiet("R5", 4);
    fifo_bytes = 12'd5; fifo_eof = 1'b1;
    serve("R5", 32'h1028, 5, 1, 0, 0, 0, 0, 0, 0, 5, 0);
    serve("R8", 32'h204, 4, 1, 1, 1, 32'h8800_002D, 0, 0, 0, 0, 0);
    fifo_eof = 1'b0;
    wait_irq("R9");
    chk(cur_ptr == 32'h200, "R9", "pointer kept on null link", cur_ptr, 32'h200);
  endtask

  task automatic t_refresh;
    rx_en = 1'b1;
    serve("R3", 32'h200, 4, 0, 1, 0, 0, 32'h300, 0, 0, 0, 1);
    serve("R9", 32'h300, 12, 0, 1, 0, 0, 32'h0, 32'h8000_0000, 0, 0, 0);
    wait_irq("R4");
    chk(cur_ptr == 32'h300, "R9", "pointer follows link", cur_ptr, 32'h300);
  endtask

  task automatic t_spill;
    ptr_in = 32'h400; ptr_wr = 1'b1; @(negedge clk); ptr_wr = 1'b0;
    chk(cur_ptr == 32'h400, "R12", "pointer loaded", cur_ptr, 32'h400);
    fifo_bytes = 12'd30; fifo_eof = 1'b1; fifo_ovr = 1'b1; rx_en = 1'b1;
    serve("R12", 32'h400, 12, 0, 1, 0, 0, 32'h500, 32'd20, 32'h2000, 0, 0);
    serve("R6", 32'h2000, 20, 1, 0, 0, 0, 0, 0, 0, 20, 0);
    serve("R7", 32'h404, 4, 1, 1, 1, 32'hC000_0014, 0, 0, 0, 0, 0);
    serve("R7", 32'h500, 12, 0, 1, 0, 0, 32'h0, 32'd64, 32'h3000, 0, 0);
    serve("R6", 32'h3000, 10, 1, 0, 0, 0, 0, 0, 0, 10, 0);
    serve("R8", 32'h504, 4, 1, 1, 1, 32'h8200_000A, 0, 0, 0, 0, 0);
    fifo_eof = 1'b0; fifo_ovr = 1'b0;
    wait_irq("R10");
    chk(cur_ptr == 32'h500, "R9", "pointer at last descriptor", cur_ptr, 32'h500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_owned();
    t_frame();
    t_refresh();
    t_spill();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule